// File: doc/BRIEF.md
# Pipelined Bus Slave Controller

This block is a memory-mapped slave on a shared system bus. It owns a small window of word addresses backed by an internal memory. Masters present read or write requests carrying a burst length and a per-request wait delay. The slave acknowledges the address and then moves one data word per cycle, signalling each word with a read or write data acknowledge. Bursts are line-relative: the words of a burst stay inside one aligned line. The words are visited either from word zero upward or starting at the requested word and wrapping.

Besides ordinary (primary) requests, the slave can take one secondary request per direction while the bus pipelines addresses. A secondary request is acknowledged and parked in a one-entry queue. It starts only after the master promotes it with that direction's primary strobe and the current transfer of that direction has drained. Configuration inputs select:
- the word order;
- automatic burst termination;
- how the wait signal behaves;
- whether secondary requests are honoured for each direction;
- whether read and write data acknowledges may coincide.

Configuration is captured during reset.

Top module: `pipe_bus_slave`

## Requirements
- R1: A request is in range only when reqAddr[AW-1:MW] equals BASE_TAG. For an out-of-range request, addrAck and waitOut both stay low.
- R2: After addrAck for a request of length code L, the slave produces L+1 data beats of that direction, starting the cycle after the acknowledge, one beat per cycle unless stalled (R12).
  - A read beat raises rdDack and presents the memory word on rdData.
  - A write beat raises wrDack and stores wrData at the end of that cycle.
- R3: In sequential order (cfgTwf=0), beat k addresses word k of the line selected by reqAddr[MW-1:LW], whatever the low address bits are.
- R4: In target-word-first order (cfgTwf=1), beat k addresses word (reqAddr[LW-1:0]+k) mod 2^LW of the same line. For example, a 4-word burst at word 2 visits 2,3,0,1.
- R5: With cfgFixedBurst=1, rdBterm or wrBterm is high exactly in the cycle of the last beat of a burst, together with its data acknowledge. With cfgFixedBurst=0, neither is ever high.
- R6: With cfgWaitOff=1, waitOut never rises, and a per-request delay does not postpone addrAck.
- R7: In address wait mode (cfgWaitDelay=0, cfgWaitOff=0), waitOut is high in every cycle in which a recognised request is presented in range, including the acknowledge cycle.
- R8: In delay wait mode (cfgWaitDelay=1), a request with delay D presented continuously is acknowledged in its D-th cycle (counting from 0), and waitOut is high in exactly the D cycles before that. With D=0 the acknowledge comes at once and waitOut stays low.
- R9: reqSecValid with reqValid low is a secondary request. When recognised for its direction, it is acknowledged while that direction's queue entry is free, even during a primary transfer. While the entry is occupied, further secondary requests of that direction get no addrAck.
- R10: A queued secondary request moves no data until rdPrim (reads) or wrPrim (writes) has been pulsed and the primary transfer of that direction has ended. Its beats then follow, after all beats of the earlier transfer.
- R11: With cfgRdPipeOff=1 (or cfgWrPipeOff=1), a secondary request of that direction gets neither addrAck nor waitOut.
- R12: With cfgSeqDack=1, rdDack and wrDack are never high in the same cycle; reads win and the write beat slips a cycle. With cfgSeqDack=0, read and write beats of concurrent transfers overlap.
- R13: All configuration inputs are sampled only while rstN is low. Changing them afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset; configuration captured while low |
| cfgTwf | input | 1 | 1 = target-word-first order, 0 = sequential |
| cfgFixedBurst | input | 1 | 1 = automatic burst terminate on last beat |
| cfgWaitOff | input | 1 | 1 = wait never asserted |
| cfgWaitDelay | input | 1 | 0 = wait on address, 1 = wait for per-request delay |
| cfgRdPipeOff | input | 1 | 1 = ignore secondary read requests |
| cfgWrPipeOff | input | 1 | 1 = ignore secondary write requests |
| cfgSeqDack | input | 1 | 1 = never acknowledge read and write data together |
| reqValid | input | 1 | Primary address valid |
| reqSecValid | input | 1 | Secondary address valid |
| reqRnW | input | 1 | 1 = read, 0 = write |
| reqAddr | input | AW | Word address |
| reqLen | input | LW | Burst length minus one |
| reqWaitDly | input | DLYW | Wait delay in cycles for delay mode |
| wrData | input | DW | Write data for the current write beat |
| rdPrim | input | 1 | Promotes the queued secondary read |
| wrPrim | input | 1 | Promotes the queued secondary write |
| addrAck | output | 1 | Address acknowledge |
| waitOut | output | 1 | Wait indication |
| rdDack | output | 1 | Read data acknowledge |
| wrDack | output | 1 | Write data acknowledge |
| rdBterm | output | 1 | Read burst terminate |
| wrBterm | output | 1 | Write burst terminate |
| rdData | output | DW | Read data, valid with rdDack |

## Verification
The hardest state to reach is a full secondary read entry that has not yet been promoted, sitting behind a primary read still moving data. The stimulus gets there in three steps:
1. It issues a four-beat primary read.
2. In the very next cycle it presents a secondary read, then a second one that must be refused.
3. It idles past the end of the primary burst to show that nothing moves without the strobe.

Only then does it pulse rdPrim and let the scoreboard confirm that the queued line follows the first one in order.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  // configuration captured during reset
  typedef struct packed {
    logic twf;
    logic fixedBurst;
    logic waitOff;
    logic waitDelay;
    logic rdPipeOff;
    logic wrPipeOff;
    logic seqDack;
  } pbs_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rdBeat;
    logic wrBeat;
  } pbs_strb_t;

endpackage

// File: rtl/pbs_dpath.sv
module pbs_dpath
  import pbs_pkg::*;
#(
  parameter int DW = 32,
  parameter int MW = 4
) (
  input  logic          clk,
  input  pbs_strb_t     strb,
  input  logic [MW-1:0] rdIdx,
  input  logic [MW-1:0] wrIdx,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << MW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrBeat) store[wrIdx] <= wrData;
  end

  assign rdData = strb.rdBeat ? store[rdIdx] : '0;
endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          MW       = 4,
  parameter int          LW       = 2,
  parameter int          DLYW     = 3,
  parameter int unsigned BASE_TAG = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  pbs_cfg_t        cfgIn,
  input  logic            reqValid,
  input  logic            reqSecValid,
  input  logic            reqRnW,
  input  logic [AW-1:0]   reqAddr,
  input  logic [LW-1:0]   reqLen,
  input  logic [DLYW-1:0] reqWaitDly,
  input  logic            rdPrim,
  input  logic            wrPrim,
  output logic            addrAck,
  output logic            waitOut,
  output logic            rdDack,
  output logic            wrDack,
  output logic            rdBterm,
  output logic            wrBterm,
  output pbs_strb_t       strb,
  output logic [MW-1:0]   rdIdx,
  output logic [MW-1:0]   wrIdx,
  output pbs_cfg_t        cfgQ
);
  localparam int TW = AW - MW;  // tag bits
  localparam int NW = MW - LW;  // line index bits

  typedef struct packed {
    logic          busy;
    logic [NW-1:0] line;
    logic [LW-1:0] start;
    logic [LW-1:0] beat;
    logic [LW-1:0] last;
  } slot_t;

  typedef struct packed {
    logic          full;
    logic          prom;
    logic [NW-1:0] line;
    logic [LW-1:0] start;
    logic [LW-1:0] last;
  } qent_t;

  // index 1 = read, index 0 = write
  slot_t prim [2];
  qent_t sec  [2];
  logic [DLYW-1:0] waitCnt;

  logic inRange, secOk, eff, dlyDone, room;
  logic [1:0] dack, primStb;
  logic [NW-1:0] reqLine;
  logic [LW-1:0] reqStart, rdWord, wrWord;

  assign reqLine  = reqAddr[MW-1:LW];
  assign reqStart = reqAddr[LW-1:0];
  assign inRange  = (reqAddr[AW-1:MW] == TW'(BASE_TAG));
  assign secOk    = reqSecValid && !reqValid &&
                    (reqRnW ? !cfgQ.rdPipeOff : !cfgQ.wrPipeOff);
  assign eff      = reqValid || secOk;
  assign dlyDone  = !cfgQ.waitDelay || cfgQ.waitOff || (waitCnt >= reqWaitDly);
  assign room     = reqValid ? (!prim[reqRnW].busy && !sec[reqRnW].full)
                             : !sec[reqRnW].full;
  assign addrAck  = eff && inRange && dlyDone && room;
  assign waitOut  = !cfgQ.waitOff && eff && inRange &&
                    (cfgQ.waitDelay ? !dlyDone : 1'b1);

  assign rdDack  = prim[1].busy;
  assign wrDack  = prim[0].busy && !(cfgQ.seqDack && prim[1].busy);
  assign rdBterm = rdDack && cfgQ.fixedBurst && (prim[1].beat == prim[1].last);
  assign wrBterm = wrDack && cfgQ.fixedBurst && (prim[0].beat == prim[0].last);
  assign dack    = {rdDack, wrDack};
  assign primStb = {rdPrim, wrPrim};

  assign rdWord = cfgQ.twf ? LW'(prim[1].start + prim[1].beat) : prim[1].beat;
  assign wrWord = cfgQ.twf ? LW'(prim[0].start + prim[0].beat) : prim[0].beat;
  assign rdIdx  = {prim[1].line, rdWord};
  assign wrIdx  = {prim[0].line, wrWord};
  assign strb   = '{rdBeat: rdDack, wrBeat: wrDack};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= cfgIn;
      waitCnt <= '0;
      for (int d = 0; d < 2; d++) begin
        prim[d] <= '0;
        sec[d]  <= '0;
      end
    end else begin
      if (eff && inRange && !addrAck) begin
        if (waitCnt != '1) waitCnt <= waitCnt + 1'b1;
      end else begin
        waitCnt <= '0;
      end
      for (int d = 0; d < 2; d++) begin
        if (dack[d]) begin
          if (prim[d].beat == prim[d].last) prim[d].busy <= 1'b0;
          else prim[d].beat <= prim[d].beat + 1'b1;
        end
        if (sec[d].full && sec[d].prom && !prim[d].busy) begin
          prim[d]     <= {1'b1, sec[d].line, sec[d].start, {LW{1'b0}}, sec[d].last};
          sec[d].full <= 1'b0;
        end
        if (primStb[d] && sec[d].full) sec[d].prom <= 1'b1;
        if (addrAck && (int'(reqRnW) == d)) begin
          if (reqValid) prim[d] <= {1'b1, reqLine, reqStart, {LW{1'b0}}, reqLen};
          else          sec[d]  <= {1'b1, 1'b0, reqLine, reqStart, reqLen};
        end
      end
    end
  end
endmodule

// File: rtl/pipe_bus_slave.sv
module pipe_bus_slave
  import pbs_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter int          MW       = 4,
  parameter int          LW       = 2,
  parameter int          DLYW     = 3,
  parameter int unsigned BASE_TAG = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgTwf,
  input  logic            cfgFixedBurst,
  input  logic            cfgWaitOff,
  input  logic            cfgWaitDelay,
  input  logic            cfgRdPipeOff,
  input  logic            cfgWrPipeOff,
  input  logic            cfgSeqDack,
  input  logic            reqValid,
  input  logic            reqSecValid,
  input  logic            reqRnW,
  input  logic [AW-1:0]   reqAddr,
  input  logic [LW-1:0]   reqLen,
  input  logic [DLYW-1:0] reqWaitDly,
  input  logic [DW-1:0]   wrData,
  input  logic            rdPrim,
  input  logic            wrPrim,
  output logic            addrAck,
  output logic            waitOut,
  output logic            rdDack,
  output logic            wrDack,
  output logic            rdBterm,
  output logic            wrBterm,
  output logic [DW-1:0]   rdData
);
  pbs_cfg_t  cfgIn, cfgQ;
  pbs_strb_t strb;
  logic [MW-1:0] rdIdx, wrIdx;

  assign cfgIn = '{twf: cfgTwf, fixedBurst: cfgFixedBurst, waitOff: cfgWaitOff,
                   waitDelay: cfgWaitDelay, rdPipeOff: cfgRdPipeOff,
                   wrPipeOff: cfgWrPipeOff, seqDack: cfgSeqDack};

  pbs_ctrl #(.AW(AW), .MW(MW), .LW(LW), .DLYW(DLYW), .BASE_TAG(BASE_TAG)) u_ctl (
    .clk, .rstN, .cfgIn, .reqValid, .reqSecValid, .reqRnW, .reqAddr, .reqLen,
    .reqWaitDly, .rdPrim, .wrPrim, .addrAck, .waitOut, .rdDack, .wrDack,
    .rdBterm, .wrBterm, .strb, .rdIdx, .wrIdx, .cfgQ
  );

  pbs_dpath #(.DW(DW), .MW(MW)) u_dp (
    .clk, .strb, .rdIdx, .wrIdx, .wrData, .rdData
  );
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk
  import pbs_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          MW       = 4,
  parameter int          DLYW     = 3,
  parameter int unsigned BASE_TAG = 10
) (
  input logic            clk,
  input logic            rstN,
  input pbs_cfg_t        cfgQ,
  input logic            reqValid,
  input logic            reqSecValid,
  input logic            reqRnW,
  input logic [AW-1:0]   reqAddr,
  input logic [DLYW-1:0] reqWaitDly,
  input logic            addrAck,
  input logic            waitOut,
  input logic            rdDack,
  input logic            wrDack,
  input logic            rdBterm,
  input logic            wrBterm
);
  localparam int TW = AW - MW;

  // R1
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqAddr[AW-1:MW] != TW'(BASE_TAG)) |-> (!addrAck && !waitOut));

  // R5
  bterm_with_dack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdBterm |-> rdDack) and (wrBterm |-> wrDack));

  // R5
  no_auto_bterm_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.fixedBurst |-> !(rdBterm || wrBterm));

  // R6
  wait_suppressed_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.waitOff |-> !waitOut);

  // R8
  delay_wait_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.waitDelay && !cfgQ.waitOff && addrAck && reqWaitDly != '0) |-> $past(waitOut));

  // R11
  sec_rd_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.rdPipeOff && reqSecValid && !reqValid && reqRnW) |-> (!addrAck && !waitOut));

  // R11
  sec_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.wrPipeOff && reqSecValid && !reqValid && !reqRnW) |-> (!addrAck && !waitOut));

  // R12
  dack_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.seqDack |-> !(rdDack && wrDack));
endmodule

bind pipe_bus_slave pbs_chk #(.AW(AW), .MW(MW), .DLYW(DLYW), .BASE_TAG(BASE_TAG)) u_chk (
  .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .reqValid(reqValid), .reqSecValid(reqSecValid),
  .reqRnW(reqRnW), .reqAddr(reqAddr), .reqWaitDly(reqWaitDly), .addrAck(addrAck),
  .waitOut(waitOut), .rdDack(rdDack), .wrDack(wrDack), .rdBterm(rdBterm), .wrBterm(wrBterm)
);

// File: tb/pipe_bus_slave_tb.sv
module pipe_bus_slave_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgTwf = 0, cfgFixedBurst = 0, cfgWaitOff = 0, cfgWaitDelay = 0;
  logic cfgRdPipeOff = 0, cfgWrPipeOff = 0, cfgSeqDack = 0;
  logic reqValid = 0, reqSecValid = 0, reqRnW = 0;
  logic [7:0] reqAddr = '0;
  logic [1:0] reqLen = '0;
  logic [2:0] reqWaitDly = '0;
  logic [31:0] wrData = '0;
  logic rdPrim = 0, wrPrim = 0;
  logic addrAck, waitOut, rdDack, wrDack, rdBterm, wrBterm;
  logic [31:0] rdData;

  int nChecks = 0, nFail = 0;
  int rdBeats = 0, overlapCnt = 0;
  bit mTwf = 0, mFixed = 0;
  logic [31:0] shadow [16];

  logic [31:0] rdExpData[$];
  bit          rdExpTerm[$];
  string       rdExpTag[$];
  logic [31:0] wrExpData[$];
  bit          wrExpTerm[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_bus_slave u_dut (
    .clk, .rstN, .cfgTwf, .cfgFixedBurst, .cfgWaitOff, .cfgWaitDelay,
    .cfgRdPipeOff, .cfgWrPipeOff, .cfgSeqDack, .reqValid, .reqSecValid, .reqRnW,
    .reqAddr, .reqLen, .reqWaitDly, .wrData, .rdPrim, .wrPrim, .addrAck, .waitOut,
    .rdDack, .wrDack, .rdBterm, .wrBterm, .rdData
  );

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: drives write data, pops the scoreboard on every beat
  initial begin
    forever begin
      @(negedge clk);
      wrData = (wrExpData.size() > 0) ? wrExpData[0] : 32'h0;
      #1;
      if (rstN) begin
        if (rdDack && wrDack) overlapCnt++;
        if (rdDack) begin
          rdBeats++;
          if (rdExpData.size() == 0) chkEq("R2 unexpected read beat", 1, 0);
          else begin
            string tg;
            tg = rdExpTag.pop_front();
            chkEq({tg, " read data"}, rdData, rdExpData.pop_front());
            chkEq("R5 read burst terminate", rdBterm, rdExpTerm.pop_front());
          end
        end
        if (wrDack) begin
          if (wrExpData.size() == 0) chkEq("R2 unexpected write beat", 1, 0);
          else begin
            void'(wrExpData.pop_front());
            chkEq("R5 write burst terminate", wrBterm, wrExpTerm.pop_front());
          end
        end
      end
    end
  end

  task automatic doReset(input bit twf, fb, woff, wdly, rpoff, wpoff, seq);
    @(negedge clk);
    rstN = 0;
    cfgTwf = twf; cfgFixedBurst = fb; cfgWaitOff = woff; cfgWaitDelay = wdly;
    cfgRdPipeOff = rpoff; cfgWrPipeOff = wpoff; cfgSeqDack = seq;
    mTwf = twf; mFixed = fb;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  // presents one request; pushes expected beats into the scoreboard when acknowledged
  task automatic issue(input bit sec, input bit rnw, input logic [7:0] addr,
                       input logic [1:0] len, input logic [2:0] dly, input logic [31:0] dBase,
                       input string tag, input int maxCyc,
                       output bit acked, output int cyc, output bit waitAtAck, output int waitCycles);
    @(negedge clk);
    reqValid = !sec; reqSecValid = sec; reqRnW = rnw;
    reqAddr = addr; reqLen = len; reqWaitDly = dly;
    acked = 0; cyc = 0; waitAtAck = 0; waitCycles = 0;
    forever begin
      #1;
      if (waitOut) waitCycles++;
      if (addrAck) begin
        acked = 1;
        waitAtAck = waitOut;
        for (int k = 0; k <= int'(len); k++) begin
          int idx;
          idx = int'(addr[3:2]) * 4 + (mTwf ? ((int'(addr[1:0]) + k) % 4) : k);
          if (rnw) begin
            rdExpData.push_back(shadow[idx]);
            rdExpTerm.push_back(mFixed && (k == int'(len)));
            rdExpTag.push_back(tag);
          end else begin
            shadow[idx] = dBase + 32'(k);
            wrExpData.push_back(dBase + 32'(k));
            wrExpTerm.push_back(mFixed && (k == int'(len)));
          end
        end
      end
      @(negedge clk);
      if (acked || cyc == maxCyc) break;
      cyc++;
    end
    reqValid = 0; reqSecValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    bit ack, wAt;
    int cyc, wc, base;
    for (int i = 0; i < 16; i++) shadow[i] = 32'hx;

    // ---- phase A: sequential, fixed bursts, address wait, overlapped dacks
    doReset(0, 1, 0, 0, 0, 0, 0);
    #1;
    chkEq("reset addrAck", addrAck, 0);
    chkEq("reset waitOut", waitOut, 0);
    chkEq("reset data acks", {rdDack, wrDack, rdBterm, wrBterm}, 0);

    issue(0, 1, 8'h32, 2'd3, 3'd0, 0, "R1", 4, ack, cyc, wAt, wc);
    chkEq("R1 out-of-range ack", ack, 0);
    chkEq("R1 out-of-range wait", wc, 0);

    issue(0, 0, 8'hA2, 2'd3, 3'd0, 32'h100, "R2", 10, ack, cyc, wAt, wc);
    chkEq("R7 wait at ack in address mode", wAt, 1);
    chkEq("R7 immediate ack", cyc, 0);
    repeat (6) @(negedge clk);
    issue(0, 0, 8'hA4, 2'd3, 3'd0, 32'h200, "R2", 10, ack, cyc, wAt, wc);
    repeat (6) @(negedge clk);
    issue(0, 0, 8'hAC, 2'd3, 3'd0, 32'h400, "R2", 10, ack, cyc, wAt, wc);
    repeat (6) @(negedge clk);
    issue(0, 1, 8'hA5, 2'd3, 3'd0, 0, "R3", 10, ack, cyc, wAt, wc);
    repeat (6) @(negedge clk);

    overlapCnt = 0;
    issue(0, 1, 8'hA0, 2'd3, 3'd0, 0, "R3", 10, ack, cyc, wAt, wc);
    issue(0, 0, 8'hA8, 2'd3, 3'd0, 32'h300, "R2", 10, ack, cyc, wAt, wc);
    repeat (8) @(negedge clk);
    chkEq("R12 overlapped dacks occur", overlapCnt > 0, 1);

    // ---- phase B: target word first, no bterm, wait off, delay mode, sequential dacks
    doReset(1, 0, 1, 1, 0, 0, 1);
    cfgWaitOff = 0;
    cfgTwf = 0;
    issue(0, 1, 8'hA2, 2'd3, 3'd3, 0, "R4", 10, ack, cyc, wAt, wc);
    chkEq("R6 delay ignored when wait off", cyc, 0);
    chkEq("R13 wait stays off after cfg change", wc, 0);
    repeat (6) @(negedge clk);
    issue(0, 1, 8'hA7, 2'd1, 3'd0, 0, "R4", 10, ack, cyc, wAt, wc);
    repeat (4) @(negedge clk);
    overlapCnt = 0;
    issue(0, 1, 8'hA4, 2'd3, 3'd0, 0, "R4", 10, ack, cyc, wAt, wc);
    issue(0, 0, 8'hAC, 2'd3, 3'd0, 32'h500, "R12", 10, ack, cyc, wAt, wc);
    repeat (10) @(negedge clk);
    chkEq("R12 no overlap in sequential dack mode", overlapCnt, 0);
    chkEq("R12 delayed write beats all done", wrExpData.size(), 0);

    // ---- phase C: sequential, fixed, delay wait, read pipelining on, write pipelining off
    doReset(0, 1, 0, 1, 0, 1, 0);
    issue(0, 1, 8'hA0, 2'd0, 3'd3, 0, "R8", 10, ack, cyc, wAt, wc);
    chkEq("R8 ack cycle for delay 3", cyc, 3);
    chkEq("R8 wait cycles for delay 3", wc, 3);
    repeat (3) @(negedge clk);
    issue(0, 1, 8'hA1, 2'd0, 3'd0, 0, "R8", 10, ack, cyc, wAt, wc);
    chkEq("R8 delay 0 ack cycle", cyc, 0);
    chkEq("R8 delay 0 wait cycles", wc, 0);
    repeat (3) @(negedge clk);

    base = rdBeats;
    issue(0, 1, 8'hA4, 2'd3, 3'd0, 0, "R10", 10, ack, cyc, wAt, wc);
    issue(1, 1, 8'hA8, 2'd3, 3'd0, 0, "R10", 0, ack, cyc, wAt, wc);
    chkEq("R9 secondary accepted during primary", ack, 1);
    issue(1, 1, 8'hAC, 2'd3, 3'd0, 0, "R9", 5, ack, cyc, wAt, wc);
    chkEq("R9 secondary refused while queue full", ack, 0);
    repeat (6) @(negedge clk);
    chkEq("R10 queued read waits for strobe", rdBeats - base, 4);
    rdPrim = 1;
    @(negedge clk);
    rdPrim = 0;
    repeat (8) @(negedge clk);
    chkEq("R10 promoted read completes", rdBeats - base, 8);
    chkEq("R10 scoreboard drained", rdExpData.size(), 0);

    issue(1, 0, 8'hA0, 2'd0, 3'd0, 32'h900, "R11", 4, ack, cyc, wAt, wc);
    chkEq("R11 secondary write ignored ack", ack, 0);
    chkEq("R11 secondary write ignored wait", wc, 0);
    repeat (4) @(negedge clk);
    chkEq("R11 no write beat from ignored request", wrExpData.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule